// File: doc/BRIEF.md
# Threshold Self-Trigger and Time Tag Unit

This block watches the sample streams of several digitizer channels. Each channel compares its samples with its own programmable threshold. When a sample first moves past that threshold, in the direction the channel has selected, the channel raises a one-cycle request. The requests of the enabled channels are combined with an external trigger input and a software strobe into one common acquisition trigger. That trigger is also stretched onto a trigger-out line so that it can reach other boards.

On the clock edge that asserts the common trigger, the block captures a time tag and a 16-bit input pattern that marks the event. The time tag is a free-running tick counter with a rollover counter above it, so together they form an extended tag. The tag is reported at two-tick resolution. An external clear zeroes the tag counters. Start and stop controls decide when triggers are accepted. A majority output gives the number of enabled channels that are requesting in the current cycle, for monitoring.

Top module: `trig_stamp_unit`

## Requirements
- R1: A channel with its direction bit at 0 raises its request for exactly one cycle, the cycle after the edge that samples a value strictly greater than its threshold, when the previously sampled value was not greater (the sampled state is "not past" out of reset).
- R2: A channel with its direction bit at 1 raises its request the same way, for a sample strictly less than its threshold after a sample that was not less.
- R3: While the level stays past the threshold no further request is raised; a new request needs at least one sample back on the other side first.
- R4: While running, `trig_o` is a one-cycle pulse two edges after any of these is sampled: a crossing on a channel whose enable bit is 1, a rising edge on `ext_trg_i`, or a cycle with `sw_trg_i` high. Requests from disabled channels are ignored.
- R5: `run_start_i` starts acceptance and `run_stop_i` stops it, with stop winning when both are high; the run state is sampled on the edge that would assert `trig_o`. Out of reset the unit is stopped.
- R6: `trig_out_o` is high for OUT_LEN cycles starting with the cycle in which `trig_o` is high, and a new trigger restarts that window.
- R7: `majority_o` equals the number of enabled channels whose request is high in the current cycle.
- R8: The tick counter (TAG_W bits) increments on every edge, and the rollover counter (ROLL_W bits) increments when the tick counter wraps. A high `tag_clr_i` zeroes both on the next edge, and the clear takes precedence.
- R9: On the edge that asserts `trig_o`, `tag_o` takes {rollover, tick} as they stood before that edge, with bit 0 forced to 0. It holds that value until the next trigger.
- R10: On the same edge `pat_o` takes `pat_i` and holds it until the next trigger.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger logic clock (8 ns tick) |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_i | input | N_CH*SW | Channel samples, channel c in bits [c*SW +: SW] |
| thr_i | input | N_CH*SW | Per-channel thresholds, same packing |
| fall_i | input | N_CH | Direction per channel: 0 over, 1 under |
| ch_en_i | input | N_CH | Channel request enables |
| ext_trg_i | input | 1 | External trigger level, rising edge used |
| sw_trg_i | input | 1 | Software trigger strobe |
| pat_i | input | PAT_W | Event marker pattern |
| run_start_i | input | 1 | Start acceptance |
| run_stop_i | input | 1 | Stop acceptance |
| tag_clr_i | input | 1 | Clear the time tag counters |
| trig_o | output | 1 | Common trigger pulse |
| trig_out_o | output | 1 | Stretched trigger for other boards |
| majority_o | output | $clog2(N_CH+1) | Count of enabled channels requesting |
| tag_o | output | TAG_W+ROLL_W | Captured time tag |
| pat_o | output | PAT_W | Captured pattern |

## Verification
A trigger capture can fall on the same edge as a tick-counter wrap or a tag clear. In that case the captured tag must show the values from before the edge, not the incremented or cleared ones. The bench narrows the tick counter to 8 bits so that wraps come often, and it mixes random clears and software strobes with channel crossings. A cycle-level reference model computes the expected tag, and every cycle's `tag_o` is compared with it. Stop and start landing on the same edge as a pending trigger are provoked the same way, and are judged on `trig_o`.

// File: rtl/trig_stamp_unit.sv
module trig_stamp_unit #(
  parameter int N_CH    = 4,
  parameter int SW      = 10,
  parameter int TAG_W   = 31,
  parameter int ROLL_W  = 17,
  parameter int PAT_W   = 16,
  parameter int OUT_LEN = 4,
  localparam int MAJ_W  = $clog2(N_CH+1),
  localparam int TS_W   = TAG_W + ROLL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CH*SW-1:0] samp_i,
  input  logic [N_CH*SW-1:0] thr_i,
  input  logic [N_CH-1:0]    fall_i,
  input  logic [N_CH-1:0]    ch_en_i,
  input  logic               ext_trg_i,
  input  logic               sw_trg_i,
  input  logic [PAT_W-1:0]   pat_i,
  input  logic               run_start_i,
  input  logic               run_stop_i,
  input  logic               tag_clr_i,
  output logic               trig_o,
  output logic               trig_out_o,
  output logic [MAJ_W-1:0]   majority_o,
  output logic [TS_W-1:0]    tag_o,
  output logic [PAT_W-1:0]   pat_o
);
  localparam int OL_W = $clog2(OUT_LEN+1);

  logic [N_CH-1:0]   past_d, past_q, req_q;
  logic              ext_q, src_q, run_q, trig_q, trig_d;
  logic [TAG_W-1:0]  cnt_q;
  logic [ROLL_W-1:0] roll_q;
  logic [TS_W-1:0]   tag_q;
  logic [PAT_W-1:0]  pat_q;
  logic [OL_W-1:0]   hold_q;
  logic [MAJ_W-1:0]  maj;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SW-1:0] s, t;
    assign s = samp_i[c*SW +: SW];
    assign t = thr_i[c*SW +: SW];
    assign past_d[c] = fall_i[c] ? (s < t) : (s > t);

    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_q[c] |=> !req_q[c]);
  end

  always_comb begin
    maj = '0;
    for (int c = 0; c < N_CH; c++)
      maj = maj + MAJ_W'(req_q[c] & ch_en_i[c]);
  end

  assign trig_d = run_q & ((|(req_q & ch_en_i)) | src_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_q <= '0;
      req_q  <= '0;
      ext_q  <= 1'b0;
      src_q  <= 1'b0;
      run_q  <= 1'b0;
      trig_q <= 1'b0;
      cnt_q  <= '0;
      roll_q <= '0;
      tag_q  <= '0;
      pat_q  <= '0;
      hold_q <= '0;
    end else begin
      past_q <= past_d;
      req_q  <= past_d & ~past_q;
      ext_q  <= ext_trg_i;
      src_q  <= (ext_trg_i & ~ext_q) | sw_trg_i;
      trig_q <= trig_d;
      if (run_stop_i)       run_q <= 1'b0;
      else if (run_start_i) run_q <= 1'b1;
      if (tag_clr_i) begin
        cnt_q  <= '0;
        roll_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) roll_q <= roll_q + 1'b1;
      end
      if (trig_d) begin
        tag_q <= {roll_q, cnt_q[TAG_W-1:1], 1'b0};
        pat_q <= pat_i;
      end
      if (trig_d)           hold_q <= OL_W'(OUT_LEN);
      else if (hold_q != 0) hold_q <= hold_q - 1'b1;
    end
  end

  assign trig_o     = trig_q;
  assign trig_out_o = hold_q != 0;
  assign majority_o = maj;
  assign tag_o      = tag_q;
  assign pat_o      = pat_q;

  p_run_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !trig_o);
  p_out_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> trig_out_o);
  p_maj_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    majority_o <= MAJ_W'(N_CH));
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_clr_i |=> (cnt_q == '0 && roll_q == '0));
  p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag_o) |-> trig_o);
  p_tag_lsb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_o[0]);
  p_pat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pat_o) |-> trig_o);
endmodule

// File: tb/trig_stamp_unit_tb.sv
`timescale 1ns/1ps
module trig_stamp_unit_tb;
  localparam int N_CH = 4, SW = 10, TAG_W = 8, ROLL_W = 8, PAT_W = 16, OUT_LEN = 3;
  localparam int MAJ_W = $clog2(N_CH+1), TS_W = TAG_W + ROLL_W;

  logic clk = 0, rst_n = 0;
  logic [N_CH*SW-1:0] samp = '0, thr = '0;
  logic [N_CH-1:0] fall = '0, en = '0;
  logic ext = 0, sw = 0, start = 0, stop = 0, clr = 0;
  logic [PAT_W-1:0] pat = '0;
  logic trig, tout;
  logic [MAJ_W-1:0] maj;
  logic [TS_W-1:0] tag;
  logic [PAT_W-1:0] pato;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N_CH-1:0] m_prev = '0, m_req = '0;
  bit m_ext = 0, m_src = 0, m_run = 0, m_trig = 0;
  logic [TAG_W-1:0] m_cnt = '0;
  logic [ROLL_W-1:0] m_roll = '0;
  logic [TS_W-1:0] m_tag = '0;
  logic [PAT_W-1:0] m_pat = '0;
  int m_hold = 0;

  always #4 clk = ~clk;

  trig_stamp_unit #(.N_CH(N_CH), .SW(SW), .TAG_W(TAG_W), .ROLL_W(ROLL_W),
    .PAT_W(PAT_W), .OUT_LEN(OUT_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .thr_i(thr), .fall_i(fall),
    .ch_en_i(en), .ext_trg_i(ext), .sw_trg_i(sw), .pat_i(pat),
    .run_start_i(start), .run_stop_i(stop), .tag_clr_i(clr),
    .trig_o(trig), .trig_out_o(tout), .majority_o(maj), .tag_o(tag), .pat_o(pato));

  function automatic int count_en(logic [N_CH-1:0] r, logic [N_CH-1:0] e);
    int n = 0;
    for (int c = 0; c < N_CH; c++) n += (r[c] & e[c]) ? 1 : 0;
    return n;
  endfunction

  function automatic bit is_past(int c, logic [N_CH*SW-1:0] s, logic [N_CH*SW-1:0] t,
                                 logic [N_CH-1:0] f);
    logic [SW-1:0] a, b;
    a = s[c*SW +: SW];
    b = t[c*SW +: SW];
    return f[c] ? (a < b) : (a > b);
  endfunction

  task automatic check(longint act, longint exp, string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [N_CH-1:0] cur;
    bit n_trig;
    for (int c = 0; c < N_CH; c++) cur[c] = is_past(c, samp, thr, fall);
    n_trig = m_run && ((count_en(m_req, en) > 0) || m_src);
    if (n_trig) begin
      m_tag = {m_roll, m_cnt} & ~TS_W'(1);
      m_pat = pat;
    end
    m_hold = n_trig ? OUT_LEN : (m_hold > 0 ? m_hold - 1 : 0);
    if (clr) begin
      m_cnt = '0; m_roll = '0;
    end else begin
      if (&m_cnt) m_roll = m_roll + 1'b1;
      m_cnt = m_cnt + 1'b1;
    end
    m_run = stop ? 0 : (start ? 1 : m_run);
    m_src = (ext & ~m_ext) | sw;
    m_ext = ext;
    m_req = cur & ~m_prev;
    m_prev = cur;
    m_trig = n_trig;
    @(posedge clk);
    @(negedge clk);
    check(trig, m_trig, "R4");
    check(tout, m_hold > 0, "R6");
    check(maj, count_en(m_req, en), "R7");
    check(tag, m_tag, "R8 R9");
    check(pato, m_pat, "R10");
  endtask

  task automatic set_ch(int c, int s);
    samp[c*SW +: SW] = SW'(s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(trig, 0, "R11"); check(tout, 0, "R11"); check(maj, 0, "R11");
    check(tag, 0, "R11"); check(pato, 0, "R11");

    thr[0*SW +: SW] = 500; thr[1*SW +: SW] = 300;
    thr[2*SW +: SW] = 1023; thr[3*SW +: SW] = 1023;
    set_ch(1, 400);
    fall = 4'b0010; en = 4'b0011;
    set_ch(0, 400); start = 1; step(); start = 0;
    set_ch(0, 600); pat = 16'hA5C3; step();
    check(maj, 1, "R1 over crossing");
    step();
    check(trig, 1, "R4 channel trigger");
    check(pato, 16'hA5C3, "R10 pattern");
    step(); check(maj, 0, "R3 no repeat while past");
    step(); check(maj, 0, "R3 no repeat while past");
    set_ch(0, 500); step(); check(maj, 0, "R1 equal is not over");
    set_ch(0, 501); step(); check(maj, 1, "R3 rearm after return");
    set_ch(1, 299); step(); check(maj, 1, "R2 under crossing");
    en = 4'b0001; set_ch(1, 400); step(); set_ch(1, 200); step();
    check(maj, 0, "R4 disabled channel ignored");
    step(); check(trig, 0, "R4 disabled channel no trigger");
    stop = 1; start = 1; step(); stop = 0; start = 0;
    sw = 1; step(); sw = 0; step(); step();
    check(trig, 0, "R5 stopped");
    clr = 1; step(); clr = 0; start = 1; step(); start = 0;
    ext = 1; step(); step(); check(trig, 1, "R4 external edge");
    step(); step(); check(trig, 0, "R4 level held no retrigger");
    ext = 0;

    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < N_CH; c++) begin
        int t = int'(thr[c*SW +: SW]);
        if ($urandom_range(0, 3) == 0) set_ch(c, t + int'($urandom_range(0, 6)) - 3);
      end
      if (i % 500 == 0) begin
        for (int c = 0; c < N_CH; c++) thr[c*SW +: SW] = SW'($urandom_range(10, 1000));
        fall = N_CH'($urandom); en = N_CH'($urandom);
      end
      ext = ($urandom_range(0, 9) == 0) ? ~ext : ext;
      sw = $urandom_range(0, 29) == 0;
      start = $urandom_range(0, 39) == 0;
      stop = $urandom_range(0, 59) == 0;
      clr = $urandom_range(0, 149) == 0;
      pat = PAT_W'($urandom);
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule